// File: doc/BRIEF.md
# Supervisory Reset and Watchdog Controller

This block generates the reset for a processor from several causes. It takes a synchronous supply-good level, an active-low manual reset request and a watchdog input that the running software must keep toggling. While any of these causes is present, reset is driven, and once the last cause clears, reset is held for a further timeout before it is released. An edge on the watchdog input in either direction restarts the watchdog window. If no edge arrives within the window, the block produces one reset pulse of timeout length.

A select input chooses between a short and a long release timeout. The block captures the select value only while no timeout is counting, so a change during a countdown takes effect from the next one. All durations are clock-cycle counts set by parameters. The reset is driven on two outputs of opposite polarity.

Top module: `sup_reset_ctrl`

## Requirements
- R1: While `supply_ok` is low, `rst_out` is high in the same cycle, with no clock edge needed.
- R2: After `supply_ok` returns high, `rst_out` stays high for exactly the selected timeout in clock cycles and then goes low.
- R3: A low on `mr_n` asserts reset within two clock edges. Reset stays asserted while `mr_n` is low. Once `mr_n` returns high, reset stays high for exactly the selected timeout plus 2 cycles, which is the latency of the two-stage synchronizer.
- R4: If `wdi` holds its level, counting from a toggle, then `rst_out` rises exactly WD_CYC+3 cycles after that toggle. The reset pulse is then exactly the selected timeout long.
- R5: Both a rising and a falling edge on `wdi` restart the watchdog window. Toggling `wdi` every 30 cycles with WD_CYC=40 never causes a reset.
- R6: The watchdog neither counts nor fires while reset is asserted. After reset goes low, the watchdog counts from zero, and with no kicks `rst_out` rises again exactly WD_CYC cycles after the release.
- R7: `tsel`=0 selects SHORT_CYC and `tsel`=1 selects LONG_CYC.
- R8: A change on `tsel` made while a timeout is counting does not alter that timeout's length.
- R9: `rst_out_n` is always the inverse of `rst_out`.
- R10: A new reset cause that arrives during a running timeout restarts the timeout from zero once that cause clears.
- R11: While `arst_n` is low, reset is asserted. After `arst_n` is released, reset is held for SHORT_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous logic initialisation, active low |
| supply_ok | input | 1 | Supply-good level, already synchronous |
| mr_n | input | 1 | Manual reset request, active low, asynchronous |
| wdi | input | 1 | Watchdog kick input, asynchronous |
| tsel | input | 1 | Timeout select: 0 short, 1 long |
| rst_out | output | 1 | Reset, active high |
| rst_out_n | output | 1 | Reset, active low |

## Verification
On every cycle, the assertions check the following:
- a low supply forces reset on the next edge;
- the watchdog counter is held at zero during reset and after every kick;
- the timeout counter stays within the latched limit, and reset is released only from its final count;
- the latched select stays fixed while a countdown runs.

Only the bench scenarios can show the exact end-to-end lengths:
- the pulse widths including synchronizer latency;
- the fact that both kick polarities count;
- the restart when a cause interrupts a countdown;
- the deferred effect of a select change.

// File: rtl/sup_reset_ctrl.sv
module sup_reset_ctrl #(
  parameter int SHORT_CYC = 15,
  parameter int LONG_CYC  = 225,
  parameter int WD_CYC    = 40
) (
  input  logic clk,
  input  logic arst_n,
  input  logic supply_ok,
  input  logic mr_n,
  input  logic wdi,
  input  logic tsel,
  output logic rst_out,
  output logic rst_out_n
);
  localparam int MAXC = (LONG_CYC > SHORT_CYC) ?
                        ((LONG_CYC > WD_CYC) ? LONG_CYC : WD_CYC) :
                        ((SHORT_CYC > WD_CYC) ? SHORT_CYC : WD_CYC);
  localparam int CW = $clog2(MAXC + 1);
  localparam logic [CW-1:0] SHORT_M1 = CW'(SHORT_CYC - 1);
  localparam logic [CW-1:0] LONG_M1  = CW'(LONG_CYC - 1);
  localparam logic [CW-1:0] WD_M1    = CW'(WD_CYC - 1);

  logic mr_s1, mr_s2, wd_s1, wd_s2, wd_prev;
  logic rst_q, sel_q;
  logic [CW-1:0] cnt, wd_cnt;
  logic cause, kick, wd_fire;
  logic [CW-1:0] limit_m1;

  assign cause    = !supply_ok || !mr_s2;
  assign kick     = wd_s2 ^ wd_prev;
  assign limit_m1 = sel_q ? LONG_M1 : SHORT_M1;
  assign wd_fire  = !rst_q && !cause && !kick && (wd_cnt == WD_M1);
  assign rst_out   = rst_q || cause;
  assign rst_out_n = !rst_out;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      mr_s1 <= 1'b1; mr_s2 <= 1'b1;
      wd_s1 <= 1'b0; wd_s2 <= 1'b0; wd_prev <= 1'b0;
    end else begin
      mr_s1 <= mr_n; mr_s2 <= mr_s1;
      wd_s1 <= wdi;  wd_s2 <= wd_s1; wd_prev <= wd_s2;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      rst_q <= 1'b1;
      cnt   <= '0;
      sel_q <= 1'b0;
    end else begin
      if (cause || wd_fire || !rst_q) sel_q <= tsel;
      if (cause || wd_fire) begin
        rst_q <= 1'b1;
        cnt   <= '0;
      end else if (rst_q) begin
        if (cnt == limit_m1) begin
          rst_q <= 1'b0;
          cnt   <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)                    wd_cnt <= '0;
    else if (rst_out || kick)       wd_cnt <= '0;
    else if (wd_cnt != WD_M1)       wd_cnt <= wd_cnt + 1'b1;
    else                            wd_cnt <= '0;
  end

  AST_SUPPLY_LOW_RESETS: assert property (@(posedge clk) disable iff (!arst_n)
    !supply_ok |=> rst_q); // R1
  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!arst_n)
    cnt <= limit_m1); // R2
  AST_RELEASE_AT_END: assert property (@(posedge clk) disable iff (!arst_n)
    (rst_q && !cause && !wd_fire && cnt == limit_m1) |=> !rst_q); // R2
  AST_KICK_CLEARS_WD: assert property (@(posedge clk) disable iff (!arst_n)
    kick |=> wd_cnt == '0); // R5
  AST_WD_FROZEN: assert property (@(posedge clk) disable iff (!arst_n)
    rst_out |=> wd_cnt == '0); // R6
  AST_SEL_HELD: assert property (@(posedge clk) disable iff (!arst_n)
    (rst_q && cnt != '0) |-> $stable(sel_q)); // R8
endmodule

// File: tb/sup_reset_ctrl_bench.sv
module sup_reset_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int S = 15, L = 225, W = 40;

  logic clk = 1'b0, arst_n = 1'b0, supply_ok = 1'b1, mr_n = 1'b1, wdi = 1'b0, tsel = 1'b0;
  logic rst_out, rst_out_n;
  int checks = 0, failures = 0, inv_bad = 0, cyc = 0;
  bit done = 0;

  sup_reset_ctrl #(.SHORT_CYC(S), .LONG_CYC(L), .WD_CYC(W)) u_sup_reset_ctrl (
    .clk(clk), .arst_n(arst_n), .supply_ok(supply_ok), .mr_n(mr_n),
    .wdi(wdi), .tsel(tsel), .rst_out(rst_out), .rst_out_n(rst_out_n));

  always #(CLK_PERIOD/2) clk = ~clk;

  // tsel at cause, tsel changed mid-count (-1 none), expected length
  localparam int VEC[4][3] = '{'{0, -1, S}, '{1, -1, L}, '{0, 1, S}, '{1, 0, L}};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic measure_high(input int change_at, input logic new_sel, output int n);
    n = 0;
    while (rst_out && n < 2000) begin
      n++;
      if (n == change_at) tsel = new_sel;
      @(negedge clk);
    end
  endtask

  task automatic measure_low(output int n);
    n = 0;
    while (!rst_out && n < 2000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_out_n !== ~rst_out) inv_bad++;
    if (cyc > 100000) begin
      checks++; failures++;
      $display("FAIL watchdog timeout actual=%0d expected=0", cyc);
      finish_run();
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk(rst_out === 1'b1, "R11 reset during arst", rst_out, 1);
    arst_n = 1'b1;
    measure_high(-1, 1'b0, n);
    chk(n == S, "R11 post-arst length", n, S);

    for (int i = 0; i < 4; i++) begin
      tsel = VEC[i][0][0];
      supply_ok = 1'b0;
      #1;
      chk(rst_out === 1'b1, "R1 immediate assert", rst_out, 1);
      repeat (3) @(negedge clk);
      supply_ok = 1'b1;
      measure_high(VEC[i][1] < 0 ? -1 : 4, VEC[i][1][0], n);
      chk(n == VEC[i][2], "R2 R7 R8 timeout length", n, VEC[i][2]);
    end

    tsel = 1'b0;
    mr_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(rst_out === 1'b1, "R3 manual assert", rst_out, 1);
    repeat (5) @(negedge clk);
    mr_n = 1'b1;
    measure_high(-1, 1'b0, n);
    chk(n == S + 2, "R3 manual release length", n, S + 2);

    measure_low(n);
    chk(n == W, "R6 watchdog resumes from zero", n, W);
    measure_high(-1, 1'b0, n);
    chk(n == S, "R4 watchdog pulse length", n, S);

    repeat (5) @(negedge clk);
    wdi = ~wdi;
    measure_low(n);
    chk(n == W + 3, "R4 watchdog expiry latency", n, W + 3);
    measure_high(-1, 1'b0, n);

    n = 0;
    for (int k = 0; k < 300; k++) begin
      if (k % 30 == 0) wdi = ~wdi;
      if (rst_out) n++;
      @(negedge clk);
    end
    chk(n == 0, "R5 both edges kick", n, 0);

    supply_ok = 1'b0;
    repeat (3) @(negedge clk);
    supply_ok = 1'b1;
    repeat (5) @(negedge clk);
    mr_n = 1'b0;
    repeat (4) @(negedge clk);
    mr_n = 1'b1;
    measure_high(-1, 1'b0, n);
    chk(n == S + 2, "R10 restart on new cause", n, S + 2);

    chk(inv_bad == 0, "R9 outputs inverse", inv_bad, 0);
    finish_run();
  end
endmodule